// File: doc/BRIEF.md
# Translate-and-Test Byte Scanner

This block scans a string of bytes in memory against a 256-entry function table and stops at the first byte whose table entry is nonzero. A scan starts with a length code L (so L+1 bytes are examined), a direction, the address of the string and the address of the table. For each element the block first fetches the string byte, then uses that byte as an unsigned offset from the table base and fetches one table byte. Both fetches share one byte-read port with a valid/ready handshake.

When a nonzero table byte is found, the block reports the address of the string byte that selected it. It puts the table byte into the low byte of a function-register output, and the upper bits of that output come from the value supplied with the start command. A condition code tells apart three cases: a stop on the final element, a stop on an earlier one, and a scan that ran to the end with no stop. The block is meant to sit beside a load/store unit in a processor or data engine that needs table-driven delimiter search, either forward or backward through the string.

Top module: `tt_scanner`

## Requirements
- R1: After reset, busy_o, rd_valid_o and done_o are 0, and cc_o, res_addr_o and func_o are all zero. While the block is idle, rd_valid_o stays 0.
- R2: In forward mode (rev_i = 0), the string byte for index i (i = 0 up to L) is read from op_base + i, modulo 2^AW.
- R3: In reverse mode (rev_i = 1), the string byte for index i is read from op_base − i, modulo 2^AW, so the address wraps below zero.
- R4: Each element takes exactly two accepted reads: the string byte first, then the table byte at tab_base + zero-extended string byte. The scan ends after the first element whose table byte is nonzero, or after index L.
- R5: On a stop, res_addr_o takes the address of the selecting string byte. func_o[7:0] takes the table byte, and func_o[FW-1:8] takes func_i[FW-1:8] as sampled at start.
- R6: cc_o is 2 when the stop happens at index L and 1 when it happens at any lower index. cc_o never shows the value 3 at completion.
- R7: If every table byte fetched is zero, cc_o becomes 0 and res_addr_o and func_o keep their previous values.
- R8: done_o is a single-cycle pulse in the cycle after the final accepted read, with busy_o already 0. cc_o holds its value until the next completion.
- R9: All command inputs are sampled when start_i is accepted in the idle state. start_i and command-input changes during a scan have no effect.
- R10: While rd_valid_o is 1 and rd_ready_i is 0, rd_valid_o stays 1 and rd_addr_o stays stable on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start command, accepted when idle |
| len_i | input | LW | Length code L; L+1 bytes are scanned |
| rev_i | input | 1 | 1 = reverse scan (addresses decrease) |
| op_base_i | input | AW | Address of string element 0 |
| tab_base_i | input | AW | Address of function table entry 0 |
| func_i | input | FW | Current function-register value (upper bits kept) |
| busy_o | output | 1 | Scan in progress |
| rd_valid_o | output | 1 | Read request valid |
| rd_addr_o | output | AW | Read byte address |
| rd_ready_i | input | 1 | Read accepted; rd_data_i valid in the same cycle |
| rd_data_i | input | 8 | Read byte data |
| done_o | output | 1 | One-cycle completion pulse |
| cc_o | output | 2 | Condition code: 0 no stop, 1 early stop, 2 stop at last |
| res_addr_o | output | AW | Address of the string byte that stopped the scan |
| func_o | output | FW | Function-register result |

## Verification
On every cycle, the assertions check the port handshake rules: an idle block makes no reads, and a stalled request holds its address. They also check that done is a single pulse that only appears while idle, that a stop loads the table byte into the low byte of the function output, and that the result outputs change only on a stop. Other behaviour depends on memory contents across a whole scan, so only the bench scenarios can show it. This covers the order of addresses in each direction (including wrap below zero), the choice of stop index and condition code, the unchanged results after a scan with no stop, and the fact that a second start during a scan is ignored.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OPND = 2'd1,
    ST_TABL = 2'd2
  } tt_state_e;

  typedef enum logic [1:0] {
    CC_NONE  = 2'd0,
    CC_EARLY = 2'd1,
    CC_LAST  = 2'd2
  } tt_cc_e;
endpackage

// File: rtl/tt_addr_gen.sv
module tt_addr_gen
  import tt_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 8
) (
  input  tt_state_e         state,
  input  logic              rev,
  input  logic [AW-1:0]     op_base,
  input  logic [AW-1:0]     tab_base,
  input  logic [LW-1:0]     idx,
  input  logic [7:0]        obyte,
  output logic [AW-1:0]     op_addr,
  output logic [AW-1:0]     rd_addr
);
  localparam int IPAD = AW - LW;
  localparam int BPAD = AW - 8;

  // string element address: base plus or minus the index
  function automatic logic [AW-1:0] elem_addr(input logic [AW-1:0] base,
                                               input logic [LW-1:0] i,
                                               input logic          dn);
    logic [AW-1:0] ext;
    ext = {{IPAD{1'b0}}, i};
    return dn ? (base - ext) : (base + ext);
  endfunction

  // table entry address: base plus unsigned byte offset
  function automatic logic [AW-1:0] entry_addr(input logic [AW-1:0] base,
                                                input logic [7:0]    b);
    return base + {{BPAD{1'b0}}, b};
  endfunction

  always_comb begin
    op_addr = elem_addr(op_base, idx, rev);
    rd_addr = (state == ST_TABL) ? entry_addr(tab_base, obyte) : op_addr;
  end
endmodule

// File: rtl/tt_seq.sv
module tt_seq
  import tt_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] len,
  input  logic          rd_ready,
  input  logic [7:0]    rd_data,
  output tt_state_e     state,
  output logic [LW-1:0] idx,
  output logic [7:0]    obyte,
  output logic          accept,
  output logic          at_last,
  output logic          hit_evt,
  output logic          end_evt,
  output logic          rd_valid
);
  logic [LW-1:0] len_q;
  logic          tab_hs;

  always_comb begin
    accept   = (state == ST_IDLE) && start;
    rd_valid = (state == ST_OPND) || (state == ST_TABL);
    at_last  = (idx == len_q);
    tab_hs   = (state == ST_TABL) && rd_ready;
    hit_evt  = tab_hs && (rd_data != 8'h00);
    end_evt  = tab_hs && ((rd_data != 8'h00) || at_last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
      len_q <= '0;
      obyte <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            len_q <= len;
            idx   <= '0;
            state <= ST_OPND;
          end
        end
        ST_OPND: begin
          if (rd_ready) begin
            obyte <= rd_data;
            state <= ST_TABL;
          end
        end
        ST_TABL: begin
          if (rd_ready) begin
            if (end_evt) begin
              state <= ST_IDLE;
            end else begin
              idx   <= idx + 1'b1;
              state <= ST_OPND;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tt_result.sv
module tt_result
  import tt_pkg::*;
#(
  parameter int AW = 32,
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_evt,
  input  logic          end_evt,
  input  logic          at_last,
  input  logic [AW-1:0] op_addr,
  input  logic [7:0]    tbyte,
  input  logic [FW-9:0] func_hi,
  output logic          done,
  output logic [1:0]    cc,
  output logic [AW-1:0] res_addr,
  output logic [FW-1:0] func
);
  function automatic tt_cc_e cc_code(input logic hit, input logic last);
    if (!hit)     return CC_NONE;
    else if (last) return CC_LAST;
    else          return CC_EARLY;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      cc       <= 2'd0;
      res_addr <= '0;
      func     <= '0;
    end else begin
      done <= end_evt;
      if (end_evt) cc <= cc_code(hit_evt, at_last);
      if (hit_evt) begin
        res_addr <= op_addr;
        func     <= {func_hi, tbyte};
      end
    end
  end
endmodule

// File: rtl/tt_scanner.sv
module tt_scanner
  import tt_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 8,
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [LW-1:0] len_i,
  input  logic          rev_i,
  input  logic [AW-1:0] op_base_i,
  input  logic [AW-1:0] tab_base_i,
  input  logic [FW-1:0] func_i,
  output logic          busy_o,
  output logic          rd_valid_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ready_i,
  input  logic [7:0]    rd_data_i,
  output logic          done_o,
  output logic [1:0]    cc_o,
  output logic [AW-1:0] res_addr_o,
  output logic [FW-1:0] func_o
);
  tt_state_e     state;
  logic [LW-1:0] idx;
  logic [7:0]    obyte;
  logic          accept, at_last, hit_evt, end_evt;
  logic [AW-1:0] op_addr;

  logic [AW-1:0] op_base_q, tab_base_q;
  logic          rev_q;
  logic [FW-9:0] func_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_base_q  <= '0;
      tab_base_q <= '0;
      rev_q      <= 1'b0;
      func_hi_q  <= '0;
    end else if (accept) begin
      op_base_q  <= op_base_i;
      tab_base_q <= tab_base_i;
      rev_q      <= rev_i;
      func_hi_q  <= func_i[FW-1:8];
    end
  end

  tt_seq #(.LW(LW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_i),
    .len      (len_i),
    .rd_ready (rd_ready_i),
    .rd_data  (rd_data_i),
    .state    (state),
    .idx      (idx),
    .obyte    (obyte),
    .accept   (accept),
    .at_last  (at_last),
    .hit_evt  (hit_evt),
    .end_evt  (end_evt),
    .rd_valid (rd_valid_o)
  );

  tt_addr_gen #(.AW(AW), .LW(LW)) u_addr (
    .state    (state),
    .rev      (rev_q),
    .op_base  (op_base_q),
    .tab_base (tab_base_q),
    .idx      (idx),
    .obyte    (obyte),
    .op_addr  (op_addr),
    .rd_addr  (rd_addr_o)
  );

  tt_result #(.AW(AW), .FW(FW)) u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_evt  (hit_evt),
    .end_evt  (end_evt),
    .at_last  (at_last),
    .op_addr  (op_addr),
    .tbyte    (rd_data_i),
    .func_hi  (func_hi_q),
    .done     (done_o),
    .cc       (cc_o),
    .res_addr (res_addr_o),
    .func     (func_o)
  );

  assign busy_o = (state != ST_IDLE);
endmodule

// File: rtl/tt_scanner_chk.sv
module tt_scanner_chk #(
  parameter int AW = 32,
  parameter int FW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_o,
  input logic          rd_valid_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          rd_ready_i,
  input logic [7:0]    rd_data_i,
  input logic          done_o,
  input logic [1:0]    cc_o,
  input logic [AW-1:0] res_addr_o,
  input logic [FW-1:0] func_o,
  input logic          hit_evt
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !rd_valid_o);

  assert_stop_on_handshake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |-> (rd_valid_o && rd_ready_i));

  assert_func_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> (func_o[7:0] == $past(rd_data_i)));

  assert_cc_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cc_o != 2'd3));

  assert_keep_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_evt |=> ($stable(res_addr_o) && $stable(func_o)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_addr_o)));
endmodule

bind tt_scanner tt_scanner_chk #(.AW(AW), .FW(FW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_o     (busy_o),
  .rd_valid_o (rd_valid_o),
  .rd_addr_o  (rd_addr_o),
  .rd_ready_i (rd_ready_i),
  .rd_data_i  (rd_data_i),
  .done_o     (done_o),
  .cc_o       (cc_o),
  .res_addr_o (res_addr_o),
  .func_o     (func_o),
  .hit_evt    (hit_evt)
);

// File: tb/tt_scanner_bench.sv
module tt_scanner_bench;
  localparam int AW = 32;
  localparam int LW = 8;
  localparam int FW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [LW-1:0] len_i = '0;
  logic          rev_i = 1'b0;
  logic [AW-1:0] op_base_i = '0;
  logic [AW-1:0] tab_base_i = '0;
  logic [FW-1:0] func_i = '0;
  logic          busy_o, rd_valid_o, done_o;
  logic [AW-1:0] rd_addr_o, res_addr_o;
  logic          rd_ready_i = 1'b0;
  logic [7:0]    rd_data_i = '0;
  logic [1:0]    cc_o;
  logic [FW-1:0] func_o;

  tt_scanner #(.AW(AW), .LW(LW), .FW(FW)) u_tt_scanner (.*);

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int done_cnt = 0;
  bit stall = 1'b0;
  logic [7:0]    mem [0:4095];
  logic [AW-1:0] log_a [0:4095];
  int            log_n = 0;

  // memory model: data and ready change away from the rising edge
  always @(negedge clk) begin
    cyc++;
    if (done_o) done_cnt++;
    rd_ready_i = stall ? (cyc % 3 == 0) : 1'b1;
    rd_data_i  = mem[rd_addr_o[11:0]];
    if (rd_valid_o && rd_ready_i && log_n < 4096) begin
      log_a[log_n] = rd_addr_o;
      log_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "R8", "watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  task automatic clear_mem();
    for (int k = 0; k < 4096; k++) mem[k] = 8'h00;
  endtask

  // independent model built from the requirements, then a run and compare
  task automatic run_scan(input string name, input logic [LW-1:0] len, input bit rev,
                          input logic [AW-1:0] ob, input logic [AW-1:0] tb,
                          input logic [FW-1:0] fin, input bit stl,
                          input bit disturb);
    logic [AW-1:0] exp_a [0:511];
    int            exp_n;
    logic [1:0]    exp_cc;
    logic [AW-1:0] exp_res;
    logic [FW-1:0] exp_func;
    int            base_n, base_done, wait_c;
    bit            stopped;
    string         dtag;
    exp_n = 0; stopped = 0;
    exp_cc = 2'd0; exp_res = res_addr_o; exp_func = func_o;
    dtag = rev ? "R3" : "R2";
    for (int i = 0; i <= int'(len) && !stopped; i++) begin
      logic [AW-1:0] a, t;
      logic [7:0] b, tv;
      a = rev ? ob - AW'(i) : ob + AW'(i);
      b = mem[a[11:0]];
      t = tb + AW'(b);
      tv = mem[t[11:0]];
      exp_a[exp_n] = a; exp_a[exp_n+1] = t; exp_n += 2;
      if (tv != 8'h00) begin
        stopped = 1;
        exp_cc = (i == int'(len)) ? 2'd2 : 2'd1;
        exp_res = a;
        exp_func = {fin[FW-1:8], tv};
      end
    end
    stall = stl;
    @(negedge clk);
    base_n = log_n; base_done = done_cnt;
    len_i = len; rev_i = rev; op_base_i = ob; tab_base_i = tb; func_i = fin;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (disturb) begin  // R9: new command and inputs mid-scan
      repeat (3) @(negedge clk);
      len_i = 8'd0; rev_i = ~rev; op_base_i = 32'h0000_0F00;
      tab_base_i = 32'h0000_0E00; func_i = 32'h1111_1111;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    wait_c = 0;
    while (!done_o && wait_c < 5000) begin @(negedge clk); wait_c++; end
    chk(done_o, "R8", {name, " done seen"}, 64'(done_o), 64'd1);
    chk(!busy_o, "R8", {name, " idle at done"}, 64'(busy_o), 64'd0);
    chk(cc_o == exp_cc, stopped ? "R6" : "R7", {name, " cc"}, 64'(cc_o), 64'(exp_cc));
    chk(res_addr_o == exp_res, stopped ? "R5" : "R7", {name, " res addr"},
        64'(res_addr_o), 64'(exp_res));
    chk(func_o == exp_func, stopped ? "R5" : "R7", {name, " func"},
        64'(func_o), 64'(exp_func));
    chk(log_n - base_n == exp_n, "R4", {name, " read count"},
        64'(log_n - base_n), 64'(exp_n));
    for (int k = 0; k < exp_n && k < log_n - base_n; k++)
      if (log_a[base_n + k] != exp_a[k])
        chk(1'b0, (k % 2 == 0) ? dtag : "R4", {name, " read addr"},
            64'(log_a[base_n + k]), 64'(exp_a[k]));
    checks++;  // address sequence check counted once
    @(negedge clk);
    chk(!done_o, "R8", {name, " done one cycle"}, 64'(done_o), 64'd0);
    if (disturb) begin
      repeat (40) @(negedge clk);
      chk(done_cnt - base_done == 1, "R9", {name, " second start ignored"},
          64'(done_cnt - base_done), 64'd1);
      chk(cc_o == exp_cc, "R9", {name, " cc unchanged later"}, 64'(cc_o), 64'(exp_cc));
    end
    stall = 1'b0;
  endtask

  task automatic t_reset();
    chk(!busy_o && !rd_valid_o && !done_o, "R1", "idle flags", 
        64'({busy_o, rd_valid_o, done_o}), 64'd0);
    chk(cc_o == 0 && res_addr_o == 0 && func_o == 0, "R1", "result regs",
        64'(res_addr_o) ^ 64'(func_o) ^ 64'(cc_o), 64'd0);
  endtask

  task automatic t_fwd_mid();  // R2 R6: early stop -> cc 1
    clear_mem();
    mem[12'h100] = 8'h10; mem[12'h101] = 8'h11; mem[12'h102] = 8'h12;
    mem[12'h103] = 8'h41; mem[12'h104] = 8'h42;
    mem[12'h841] = 8'h5A; mem[12'h842] = 8'h77;
    run_scan("fwd_mid", 8'd7, 1'b0, 32'h100, 32'h800, 32'hABCD_EF12, 1'b0, 1'b0);
  endtask

  task automatic t_fwd_last();  // R6: stop at index L -> cc 2
    clear_mem();
    mem[12'h200] = 8'h01; mem[12'h205] = 8'hFF;
    mem[12'h8FF] = 8'h3C;
    run_scan("fwd_last", 8'd5, 1'b0, 32'h200, 32'h800, 32'h0102_0300, 1'b0, 1'b0);
  endtask

  task automatic t_fwd_none();  // R7: all zero -> cc 0, results kept
    clear_mem();
    for (int k = 0; k < 9; k++) mem[12'h300 + k] = 8'(k * 7);
    run_scan("fwd_none", 8'd8, 1'b0, 32'h300, 32'h800, 32'hDEAD_BEEF, 1'b0, 1'b0);
  endtask

  task automatic t_rev_stall();  // R3 R10: reverse with wait states
    clear_mem();
    mem[12'h410] = 8'h05; mem[12'h40F] = 8'h06; mem[12'h40E] = 8'h20;
    mem[12'h820] = 8'h99; mem[12'h806] = 8'h00;
    run_scan("rev_stall", 8'd6, 1'b1, 32'h410, 32'h800, 32'h5555_AAAA, 1'b1, 1'b0);
  endtask

  task automatic t_rev_wrap();  // R3 R6: address wraps below zero, stop at L
    clear_mem();
    mem[12'hFFE] = 8'hC3; mem[12'h8C3] = 8'h01;
    run_scan("rev_wrap", 8'd4, 1'b1, 32'h2, 32'h800, 32'h7700_0000, 1'b0, 1'b0);
  endtask

  task automatic t_single();  // R6: L = 0, one byte hit -> cc 2
    clear_mem();
    mem[12'h500] = 8'h80; mem[12'h880] = 8'hE1;
    run_scan("single", 8'd0, 1'b0, 32'h500, 32'h800, 32'hFFFF_FF00, 1'b0, 1'b0);
  endtask

  task automatic t_first();  // R6: hit at index 0 with L > 0 -> cc 1
    clear_mem();
    mem[12'h600] = 8'h33; mem[12'h833] = 8'h02;
    run_scan("first", 8'd3, 1'b0, 32'h600, 32'h800, 32'h0000_0000, 1'b1, 1'b0);
  endtask

  task automatic t_busy_start();  // R9: start and input changes ignored mid-scan
    clear_mem();
    mem[12'h700] = 8'h01; mem[12'h701] = 8'h02; mem[12'h702] = 8'h03;
    mem[12'h703] = 8'h44; mem[12'h844] = 8'h6B;
    mem[12'hF00] = 8'h10; mem[12'hE10] = 8'hEE;
    run_scan("busy_start", 8'd5, 1'b0, 32'h700, 32'h800, 32'hCAFE_0000, 1'b1, 1'b1);
  endtask

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fwd_mid();
    t_fwd_last();
    t_fwd_none();
    t_rev_stall();
    t_rev_wrap();
    t_single();
    t_first();
    t_busy_start();
    finish_run();
  end
endmodule